// File: doc/BRIEF.md
# Flash Controller Unlock and Command Sequencer

This block sits between a register bus and a paged flash array and decides when a program or erase operation may reach the array. Software cannot issue commands at reset. It must first write a two-byte key to the control register. Any wrong byte in that key sends the sequencer back to the fully locked state. Once the key is accepted, software can start a page erase, a mass erase or byte programs. These operations go to the array as a one-cycle strobe. The strobe carries an operation code, a page, an offset and a data byte.

Each operation is checked before it is granted. The checks are the selected page, a two-bit protection level input, and a 16-bit frequency value that must be non-zero. If an operation fails any check, it is dropped and the key is cleared. A granted operation holds a busy flag for a number of cycles derived from the frequency value. While the flag is set, control, page and frequency writes are ignored, and so are program requests. The status register, which is read-only, shares its address with the write-only control register.

Top module: `flash_cmd_seq`

## Requirements
- R1: After reset the lock state is 0, busy is low, the page and frequency registers read 0, and fl_strobe is low.
- R2: In lock state 0, a control write of 73H moves to lock state 1. Any other control value leaves the state at 0.
- R3: In lock state 1, a control write of 8CH moves to lock state 2 (open). Any other control value returns to state 0.
- R4: In lock state 2, a control write of FFH, or of any value other than 95H or 63H, returns to lock state 0.
- R5: In lock state 2, a control write of 95H starts a page erase of the selected page. In the next cycle, fl_strobe is high for one cycle with fl_cmd=2, fl_page equal to the page register, fl_off=0 and fl_wdata=FFH. Busy is then high for 4×frequency cycles, starting with the strobe cycle. The lock state stays at 2.
- R6: A control write of 63H in lock state 2 starts a mass erase (fl_cmd=3, fl_page=0, busy for 8×frequency cycles). It is granted only when the protection level is 00.
- R7: A program request in lock state 2 is granted only if the address page field (prog_addr[15:9]) equals the page register. When granted, it produces fl_cmd=1 with that page, fl_off=prog_addr[8:0], fl_wdata=prog_data, and busy for frequency cycles. If a control write occurs in the same cycle, the control write wins.
- R8: An operation is refused if its target is protected, if the frequency value is 0, or, for a program request, if the page does not match. A refused operation produces no strobe and returns the lock state to 0.
- R9: While busy is high, control writes, page and frequency writes, and program requests have no effect.
- R10: Reads return combinationally. Address 0 gives status {busy, 5'b0, lock[1:0]}. Address 1 gives the page register (7 bits, zero-extended; a write keeps wr_data[6:0]). Address 2 gives the frequency high byte and address 3 the frequency low byte. Writes use the same addresses, and address 0 is the control register.
- R11: prot_lvl 00 protects nothing. prot_lvl 01 protects pages 64 to 127. prot_lvl 10 or 11 protects the whole array.
- R12: A program request in lock state 0 or 1 has no effect: no strobe and no change of lock state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register write address |
| wr_data | input | 8 | Register write data |
| rd_addr | input | 2 | Register read address |
| rd_data | output | 8 | Register read data (combinational) |
| prog_req | input | 1 | Byte program request |
| prog_addr | input | 16 | Program byte address {page, offset} |
| prog_data | input | 8 | Program data byte |
| prot_lvl | input | 2 | Protection level |
| busy | output | 1 | Operation in progress |
| fl_strobe | output | 1 | One-cycle operation strobe to the array |
| fl_cmd | output | 2 | Operation code: 0 none, 1 program, 2 page erase, 3 mass erase |
| fl_page | output | 7 | Target page |
| fl_off | output | 9 | Byte offset in page |
| fl_wdata | output | 8 | Program data |

## Verification
A register write or program request seen at clock edge k changes the lock state, and any granted strobe, in the cycle after k. Busy rises in that same cycle and stays high for the computed duration. Status reads are combinational, so a read placed in the cycle after a write shows the new state. The driver applies inputs on the falling edge and pushes each expected strobe into a queue before issuing it. A monitor samples on falling edges: on each strobe it pops the queue, compares the fields, and counts the busy cycles starting with the strobe cycle. Any strobe that arrives with the queue empty is reported as a failure. This is how refused and ignored operations are detected.

// File: rtl/fc_pkg.sv
package fc_pkg;
  typedef enum logic [1:0] {
    LK_SHUT = 2'd0,
    LK_HALF = 2'd1,
    LK_OPEN = 2'd2
  } lock_e;

  typedef enum logic [1:0] {
    OP_NONE   = 2'd0,
    OP_PROG   = 2'd1,
    OP_PERASE = 2'd2,
    OP_MERASE = 2'd3
  } op_e;

  localparam logic [7:0] KEY_FIRST  = 8'h73;
  localparam logic [7:0] KEY_SECOND = 8'h8C;
  localparam logic [7:0] CMD_PERASE = 8'h95;
  localparam logic [7:0] CMD_MERASE = 8'h63;
  localparam logic [7:0] CMD_RELOCK = 8'hFF;

  localparam logic [1:0] REG_CTL  = 2'd0;
  localparam logic [1:0] REG_PAGE = 2'd1;
  localparam logic [1:0] REG_FHI  = 2'd2;
  localparam logic [1:0] REG_FLO  = 2'd3;
endpackage

// File: rtl/fc_guard.sv
module fc_guard
  import fc_pkg::*;
#(
  parameter int PAGE_W   = 7,
  parameter int HI_FIRST = 64
) (
  input  op_e               op,
  input  logic [PAGE_W-1:0] tgt_page,
  input  logic [PAGE_W-1:0] sel_page,
  input  logic [1:0]        prot_lvl,
  input  logic              freq_set,
  output logic              grant
);
  logic tgt_locked;
  logic sel_locked;

  always_comb begin
    tgt_locked = prot_lvl[1] | (prot_lvl[0] & (int'(tgt_page) >= HI_FIRST));
    sel_locked = prot_lvl[1] | (prot_lvl[0] & (int'(sel_page) >= HI_FIRST));
    case (op)
      OP_PROG:   grant = freq_set & (tgt_page == sel_page) & ~tgt_locked;
      OP_PERASE: grant = freq_set & ~sel_locked;
      OP_MERASE: grant = freq_set & (prot_lvl == 2'b00);
      default:   grant = 1'b0;
    endcase
  end
endmodule

// File: rtl/fc_lock_fsm.sv
module fc_lock_fsm
  import fc_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ctl_wr,
  input  logic [7:0] ctl_data,
  input  logic       prog_try,
  input  logic       grant,
  output lock_e      lock_q,
  output op_e        op_req,
  output logic       issue
);
  lock_e lock_d;

  always_comb begin
    lock_d = lock_q;
    op_req = OP_NONE;
    case (lock_q)
      LK_SHUT: if (ctl_wr && ctl_data == KEY_FIRST) lock_d = LK_HALF;
      LK_HALF: if (ctl_wr) lock_d = (ctl_data == KEY_SECOND) ? LK_OPEN : LK_SHUT;
      LK_OPEN: begin
        if (ctl_wr) begin
          if (ctl_data == CMD_PERASE)      op_req = OP_PERASE;
          else if (ctl_data == CMD_MERASE) op_req = OP_MERASE;
          else                             lock_d = LK_SHUT;
        end else if (prog_try) begin
          op_req = OP_PROG;
        end
      end
      default: lock_d = LK_SHUT;
    endcase
    if (op_req != OP_NONE && !grant) lock_d = LK_SHUT;
  end

  assign issue = (op_req != OP_NONE) && grant;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) lock_q <= LK_SHUT;
    else        lock_q <= lock_d;
  end

  assert_half_from_key_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (lock_q == LK_HALF && $past(lock_q) != LK_HALF) |->
      ($past(lock_q) == LK_SHUT && $past(ctl_wr) && $past(ctl_data) == KEY_FIRST));

  assert_open_from_key_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (lock_q == LK_OPEN && $past(lock_q) != LK_OPEN) |->
      ($past(lock_q) == LK_HALF && $past(ctl_data) == KEY_SECOND));

  assert_relock_leaves_open_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(lock_q) == LK_OPEN && $past(ctl_wr) && $past(ctl_data) == CMD_RELOCK) |->
      lock_q == LK_SHUT);
endmodule

// File: rtl/fc_busy_timer.sv
module fc_busy_timer
  import fc_pkg::*;
#(
  parameter int FREQ_W    = 16,
  parameter int PROG_SH   = 0,
  parameter int PERASE_SH = 2,
  parameter int MERASE_SH = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  op_e               op,
  input  logic [FREQ_W-1:0] freq,
  output logic              busy
);
  localparam int CNT_W = FREQ_W + MERASE_SH;

  logic [CNT_W-1:0] cnt_q, cnt_d, fext, dur;
  logic             cnt_en;

  always_comb begin
    fext = {{MERASE_SH{1'b0}}, freq};
    case (op)
      OP_PROG:   dur = fext << PROG_SH;
      OP_PERASE: dur = fext << PERASE_SH;
      OP_MERASE: dur = fext << MERASE_SH;
      default:   dur = '0;
    endcase
    cnt_en = load | (cnt_q != '0);
    cnt_d  = load ? dur : cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign busy = (cnt_q != '0);

  assert_busy_countdown_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(busy) && !$past(load)) |-> cnt_q == $past(cnt_q) - 1'b1);
endmodule

// File: rtl/flash_cmd_seq.sv
module flash_cmd_seq
  import fc_pkg::*;
#(
  parameter int PAGES      = 128,
  parameter int PAGE_BYTES = 512,
  parameter int FREQ_W     = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en,
  input  logic [1:0] wr_addr,
  input  logic [7:0] wr_data,
  input  logic [1:0] rd_addr,
  output logic [7:0] rd_data,
  input  logic       prog_req,
  input  logic [$clog2(PAGES)+$clog2(PAGE_BYTES)-1:0] prog_addr,
  input  logic [7:0] prog_data,
  input  logic [1:0] prot_lvl,
  output logic       busy,
  output logic       fl_strobe,
  output logic [1:0] fl_cmd,
  output logic [$clog2(PAGES)-1:0] fl_page,
  output logic [$clog2(PAGE_BYTES)-1:0] fl_off,
  output logic [7:0] fl_wdata
);
  localparam int PAGE_W   = $clog2(PAGES);
  localparam int OFF_W    = $clog2(PAGE_BYTES);
  localparam int HI_FIRST = PAGES / 2;

  logic [PAGE_W-1:0] page_q;
  logic [7:0]        fhi_q, flo_q;
  logic              cfg_ok, ctl_wr, prog_try, grant, issue;
  logic              page_en, fhi_en, flo_en;
  lock_e             lock_q;
  op_e               op_req;
  logic [PAGE_W-1:0] tgt_page;

  assign cfg_ok   = wr_en & ~busy;
  assign ctl_wr   = cfg_ok & (wr_addr == REG_CTL);
  assign page_en  = cfg_ok & (wr_addr == REG_PAGE);
  assign fhi_en   = cfg_ok & (wr_addr == REG_FHI);
  assign flo_en   = cfg_ok & (wr_addr == REG_FLO);
  assign prog_try = prog_req & ~busy;
  assign tgt_page = prog_addr[PAGE_W+OFF_W-1:OFF_W];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      page_q <= '0;
      fhi_q  <= '0;
      flo_q  <= '0;
    end else begin
      if (page_en) page_q <= wr_data[PAGE_W-1:0];
      if (fhi_en)  fhi_q  <= wr_data;
      if (flo_en)  flo_q  <= wr_data;
    end
  end

  fc_lock_fsm u_fsm (
    .clk(clk), .rst_n(rst_n), .ctl_wr(ctl_wr), .ctl_data(wr_data),
    .prog_try(prog_try), .grant(grant), .lock_q(lock_q),
    .op_req(op_req), .issue(issue)
  );

  fc_guard #(.PAGE_W(PAGE_W), .HI_FIRST(HI_FIRST)) u_guard (
    .op(op_req), .tgt_page(tgt_page), .sel_page(page_q),
    .prot_lvl(prot_lvl), .freq_set({fhi_q, flo_q} != 16'h0000), .grant(grant)
  );

  fc_busy_timer #(.FREQ_W(FREQ_W)) u_timer (
    .clk(clk), .rst_n(rst_n), .load(issue), .op(op_req),
    .freq({fhi_q, flo_q}), .busy(busy)
  );

  // Array-side outputs, registered at the grant edge.
  logic [1:0]        cmd_d;
  logic [PAGE_W-1:0] pg_d;
  logic [OFF_W-1:0]  off_d;
  logic [7:0]        dat_d;

  always_comb begin
    cmd_d = issue ? op_req : OP_NONE;
    pg_d  = '0;
    off_d = '0;
    dat_d = 8'hFF;
    if (op_req == OP_PROG) begin
      pg_d  = tgt_page;
      off_d = prog_addr[OFF_W-1:0];
      dat_d = prog_data;
    end else if (op_req == OP_PERASE) begin
      pg_d  = page_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fl_strobe <= 1'b0;
      fl_cmd    <= OP_NONE;
      fl_page   <= '0;
      fl_off    <= '0;
      fl_wdata  <= '0;
    end else begin
      fl_strobe <= issue;
      fl_cmd    <= cmd_d;
      if (issue) begin
        fl_page  <= pg_d;
        fl_off   <= off_d;
        fl_wdata <= dat_d;
      end
    end
  end

  always_comb begin
    case (rd_addr)
      REG_CTL:  rd_data = {busy, 5'b0, lock_q};
      REG_PAGE: rd_data = {{(8-PAGE_W){1'b0}}, page_q};
      REG_FHI:  rd_data = fhi_q;
      default:  rd_data = flo_q;
    endcase
  end

  assert_strobe_from_open_R8: assert property (@(posedge clk) disable iff (!rst_n)
    fl_strobe |-> $past(lock_q) == LK_OPEN);

  assert_strobe_sets_busy_R5: assert property (@(posedge clk) disable iff (!rst_n)
    fl_strobe |-> busy);

  assert_no_strobe_while_busy_R9: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> !fl_strobe);

  assert_mass_needs_no_prot_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (fl_strobe && fl_cmd == OP_MERASE) |-> $past(prot_lvl) == 2'b00);

  assert_prog_page_match_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (fl_strobe && fl_cmd == OP_PROG) |-> fl_page == $past(page_q));
endmodule

// File: tb/flash_cmd_seq_tb_top.sv
module flash_cmd_seq_tb_top;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        wr_en;
  logic [1:0]  wr_addr, rd_addr, prot_lvl, fl_cmd;
  logic [7:0]  wr_data, rd_data, prog_data, fl_wdata;
  logic        prog_req, busy, fl_strobe;
  logic [15:0] prog_addr;
  logic [6:0]  fl_page;
  logic [8:0]  fl_off;

  always #5 clk = ~clk;

  flash_cmd_seq dut_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .prog_req(prog_req), .prog_addr(prog_addr),
    .prog_data(prog_data), .prot_lvl(prot_lvl), .busy(busy), .fl_strobe(fl_strobe),
    .fl_cmd(fl_cmd), .fl_page(fl_page), .fl_off(fl_off), .fl_wdata(fl_wdata)
  );

  int checks = 0;
  int errors = 0;

  typedef struct {
    logic [1:0] cmd;
    logic [6:0] page;
    logic [8:0] off;
    logic [7:0] data;
    int         len;
    string      req;
  } exp_t;
  exp_t exp_q[$];

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  // Monitor: compare every strobe against the scoreboard queue.
  always @(negedge clk) begin : mon
    exp_t e;
    int   n;
    if (rst_n === 1'b1 && fl_strobe === 1'b1) begin
      if (exp_q.size() == 0) begin
        checks++;
        errors++;
        $display("FAIL R8/R9/R12 unexpected strobe: actual cmd %0d expected none", fl_cmd);
      end else begin
        e = exp_q.pop_front();
        chk(e.req, "fl_cmd", int'(fl_cmd), int'(e.cmd));
        chk(e.req, "fl_page", int'(fl_page), int'(e.page));
        chk(e.req, "fl_off", int'(fl_off), int'(e.off));
        chk(e.req, "fl_wdata", int'(fl_wdata), int'(e.data));
        n = 0;
        while (busy) begin
          n++;
          @(negedge clk);
        end
        chk(e.req, "busy cycles", n, e.len);
      end
    end
  end

  task automatic push(input logic [1:0] c, input logic [6:0] p, input logic [8:0] o,
                      input logic [7:0] d, input int len, input string req);
    exp_t e;
    e.cmd = c; e.page = p; e.off = o; e.data = d; e.len = len; e.req = req;
    exp_q.push_back(e);
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic prog(input logic [6:0] p, input logic [8:0] o, input logic [7:0] d);
    prog_req = 1'b1; prog_addr = {p, o}; prog_data = d;
    @(negedge clk);
    prog_req = 1'b0;
  endtask

  task automatic rd_chk(input logic [1:0] a, input int exp, input string req);
    rd_addr = a;
    #1;
    chk(req, $sformatf("read addr %0d", a), int'(rd_data), exp);
  endtask

  task automatic unlock();
    wr(2'd0, 8'h73);
    wr(2'd0, 8'h8C);
  endtask

  task automatic wait_idle();
    @(negedge clk);
    while (busy) @(negedge clk);
    repeat (2) @(negedge clk);
  endtask

  initial begin : watchdog
    repeat (50000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual hung expected finish");
    summary();
  end

  initial begin : driver
    rst_n = 1'b0; wr_en = 1'b0; wr_addr = '0; wr_data = '0; rd_addr = '0;
    prog_req = 1'b0; prog_addr = '0; prog_data = '0; prot_lvl = 2'b00;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    chk("R1", "fl_strobe", int'(fl_strobe), 0);
    chk("R1", "busy", int'(busy), 0);
    rd_chk(2'd0, 8'h00, "R1");
    rd_chk(2'd1, 8'h00, "R1");
    rd_chk(2'd2, 8'h00, "R1");
    rd_chk(2'd3, 8'h00, "R1");

    // R2 first key
    wr(2'd0, 8'h12);  rd_chk(2'd0, 8'h00, "R2");
    wr(2'd0, 8'h73);  rd_chk(2'd0, 8'h01, "R2");
    // R3 wrong second key
    wr(2'd0, 8'h73);  rd_chk(2'd0, 8'h00, "R3");
    unlock();         rd_chk(2'd0, 8'h02, "R3");
    // R4 relock
    wr(2'd0, 8'hFF);  rd_chk(2'd0, 8'h00, "R4");
    unlock();
    wr(2'd0, 8'h11);  rd_chk(2'd0, 8'h00, "R4");

    // R8 frequency zero refuses
    unlock();
    wr(2'd0, 8'h95);  rd_chk(2'd0, 8'h00, "R8");

    // R10 frequency and page readback
    wr(2'd2, 8'hA5);  rd_chk(2'd2, 8'hA5, "R10");
    wr(2'd2, 8'h00);
    wr(2'd3, 8'h03);  rd_chk(2'd3, 8'h03, "R10");
    wr(2'd1, 8'hFF);  rd_chk(2'd1, 8'h7F, "R10");
    wr(2'd1, 8'h05);  rd_chk(2'd1, 8'h05, "R10");

    // R5 page erase
    unlock();
    push(2'd2, 7'd5, 9'd0, 8'hFF, 12, "R5");
    wr(2'd0, 8'h95);
    wait_idle();
    rd_chk(2'd0, 8'h02, "R5");

    // R6 mass erase, R9 ignored during busy
    push(2'd3, 7'd0, 9'd0, 8'hFF, 24, "R6");
    wr(2'd0, 8'h63);
    rd_chk(2'd0, 8'h82, "R10");
    wr(2'd0, 8'hFF);
    wr(2'd1, 8'h09);
    wr(2'd3, 8'h07);
    prog(7'd5, 9'd1, 8'h33);
    wait_idle();
    rd_chk(2'd0, 8'h02, "R9");
    rd_chk(2'd1, 8'h05, "R9");
    rd_chk(2'd3, 8'h03, "R9");

    // R7 program, then page mismatch refused
    push(2'd1, 7'd5, 9'h1A3, 8'h5C, 3, "R7");
    prog(7'd5, 9'h1A3, 8'h5C);
    wait_idle();
    rd_chk(2'd0, 8'h02, "R7");
    prog(7'd6, 9'h010, 8'h11);
    rd_chk(2'd0, 8'h00, "R8");

    // R12 program ignored while locked or half-keyed
    prog(7'd5, 9'h002, 8'h44);
    rd_chk(2'd0, 8'h00, "R12");
    wr(2'd0, 8'h73);
    prog(7'd5, 9'h002, 8'h44);
    rd_chk(2'd0, 8'h01, "R12");
    wr(2'd0, 8'h00);

    // R11 upper-half protection
    prot_lvl = 2'b01;
    wr(2'd1, 8'd70);
    unlock();
    wr(2'd0, 8'h95);  rd_chk(2'd0, 8'h00, "R11");
    wr(2'd1, 8'd63);
    unlock();
    push(2'd2, 7'd63, 9'd0, 8'hFF, 12, "R11");
    wr(2'd0, 8'h95);
    wait_idle();
    wr(2'd0, 8'h63);  rd_chk(2'd0, 8'h00, "R6");
    // R11 whole-array protection
    prot_lvl = 2'b10;
    wr(2'd1, 8'd3);
    unlock();
    wr(2'd0, 8'h95);  rd_chk(2'd0, 8'h00, "R11");
    unlock();
    prog(7'd3, 9'd0, 8'h01);
    rd_chk(2'd0, 8'h00, "R11");

    // R5 boundary: last page, no protection
    prot_lvl = 2'b00;
    wr(2'd1, 8'd127);
    unlock();
    push(2'd2, 7'd127, 9'd0, 8'hFF, 12, "R5");
    wr(2'd0, 8'h95);
    wait_idle();

    repeat (4) @(negedge clk);
    chk("R5-R8 scoreboard", "pending items", exp_q.size(), 0);
    summary();
  end
endmodule